// File: doc/BRIEF.md
# Service-Qualified Enable and Chip-Select Gate

This block sits beside a voltage and watchdog supervisor and turns its reset level and its "serviced in the open window" strobe into an active-low system enable. After any reset, the enable is held off until software has serviced the watchdog correctly several times in a row. The default is three times. A system that keeps restarting therefore never reaches the point where it can drive critical loads such as motor drivers.

The same enable gates a set of active-low chip-select lines. While the enable is withheld, every chip-select output is forced deasserted. Once the enable is granted, each output follows its input with no register in the path. A supply or input-voltage fault reaches the block as the supervisor's reset and withdraws the enable at once, without waiting for a clock. The block does not generate any window timing: it only counts strobes that the supervisor has already qualified.

Top module: `svc_enable_gate`

## Requirements
- R1: While `sup_rst_n` is low, `en_n` is high (inactive). This holds immediately and does not wait for a clock edge.
- R2: After `sup_rst_n` rises, `en_n` stays high until the third clock edge at which `svc_stb` is high. It is low from that edge onward.
- R3: A low level on `sup_rst_n` clears the service count to zero. Services counted before a reset do not count toward the next grant.
- R4: Once `en_n` is low, it stays low for every further `svc_stb` pulse until the next reset. The count saturates and does not wrap.
- R5: While `en_n` is high, every bit of `cs_out_n` is 1, whatever `cs_in_n` is.
- R6: While `en_n` is low, `cs_out_n` equals `cs_in_n` bit for bit, combinationally. Bit i of the output follows bit i of the input.
- R7: `svc_stb` pulses that arrive while `sup_rst_n` is low are not counted.
- R8: The count advances only on clock edges where `svc_stb` is high. Any number of cycles without a strobe leaves `en_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples the service strobe |
| sup_rst_n | input | 1 | Supervisor reset level, active low; also clears the count asynchronously |
| svc_stb | input | 1 | Single-cycle strobe marking one correct in-window service |
| cs_in_n | input | CS_LANES (3) | Active-low chip-select requests |
| en_n | output | 1 | Active-low system enable |
| cs_out_n | output | CS_LANES (3) | Active-low gated chip selects |

## Verification
The grant path is exercised with clean runs of consecutive strobes. It is also exercised with two strobes followed by a reset, which separates a design that clears the count on reset from one that keeps it. Further runs place strobes during reset, idle gaps between strobes, and extra strobes after the grant; these show whether the count is gated, tied to the strobe, and saturating. The chip-select patterns are all zeros, all ones and one lane at a time, applied both with the enable withheld and with it granted. They show whether lanes are swapped or the gate is inverted. A reset that drops in the middle of a cycle tests that the enable is withdrawn immediately.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int unsigned SVC_TARGET_DEF = 3;
    localparam int unsigned CS_LANES_DEF   = 3;

    function automatic int unsigned cnt_bits(input int unsigned target);
        return (target < 2) ? 1 : $clog2(target + 1);
    endfunction
endpackage

// File: rtl/seg_svc_counter.sv
module seg_svc_counter #(
    parameter int unsigned SVC_TARGET = seg_pkg::SVC_TARGET_DEF
) (
    input  logic clk,
    input  logic sup_rst_n,
    input  logic svc_stb,
    output logic grant
);
    localparam int unsigned CNT_W = seg_pkg::cnt_bits(SVC_TARGET);
    localparam logic [CNT_W-1:0] TGT = CNT_W'(SVC_TARGET);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             grant;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (svc_stb && (st_q.cnt != TGT)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.grant = (st_d.cnt == TGT);
    end

    always_ff @(posedge clk or negedge sup_rst_n) begin
        if (!sup_rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.grant;
endmodule

// File: rtl/seg_cs_gate.sv
module seg_cs_gate #(
    parameter int unsigned CS_LANES = seg_pkg::CS_LANES_DEF
) (
    input  logic                en_n,
    input  logic [CS_LANES-1:0] cs_in_n,
    output logic [CS_LANES-1:0] cs_out_n
);
    for (genvar i = 0; i < CS_LANES; i++) begin : g_lane
        assign cs_out_n[i] = cs_in_n[i] | en_n;
    end
endmodule

// File: rtl/svc_enable_gate.sv
module svc_enable_gate #(
    parameter int unsigned SVC_TARGET = seg_pkg::SVC_TARGET_DEF,
    parameter int unsigned CS_LANES   = seg_pkg::CS_LANES_DEF
) (
    input  logic                clk,
    input  logic                sup_rst_n,
    input  logic                svc_stb,
    input  logic [CS_LANES-1:0] cs_in_n,
    output logic                en_n,
    output logic [CS_LANES-1:0] cs_out_n
);
    logic grant;

    seg_svc_counter #(.SVC_TARGET(SVC_TARGET)) u_cnt (
        .clk       (clk),
        .sup_rst_n (sup_rst_n),
        .svc_stb   (svc_stb),
        .grant     (grant)
    );

    // reset level also gates directly so a fault needs no clock
    assign en_n = ~(grant & sup_rst_n);

    seg_cs_gate #(.CS_LANES(CS_LANES)) u_gate (
        .en_n     (en_n),
        .cs_in_n  (cs_in_n),
        .cs_out_n (cs_out_n)
    );
endmodule

// File: rtl/seg_checker.sv
module seg_checker #(
    parameter int unsigned SVC_TARGET = seg_pkg::SVC_TARGET_DEF,
    parameter int unsigned CS_LANES   = seg_pkg::CS_LANES_DEF
) (
    input logic                clk,
    input logic                sup_rst_n,
    input logic                svc_stb,
    input logic [CS_LANES-1:0] cs_in_n,
    input logic                en_n,
    input logic [CS_LANES-1:0] cs_out_n
);
    localparam int unsigned CW = seg_pkg::cnt_bits(SVC_TARGET);
    localparam logic [CW-1:0] TGT = CW'(SVC_TARGET);

    logic [CW-1:0] seen_q;
    always_ff @(posedge clk or negedge sup_rst_n) begin
        if (!sup_rst_n)                  seen_q <= '0;
        else if (svc_stb && seen_q != TGT) seen_q <= seen_q + 1'b1;
    end

    always_comb begin
        if (sup_rst_n === 1'b0) begin
            a_r1_reset_blocks: assert (en_n === 1'b1);
        end
        if (en_n === 1'b1) begin
            a_r5_cs_forced_high: assert (cs_out_n === '1);
        end
        if (en_n === 1'b0) begin
            a_r6_cs_follows: assert (cs_out_n === cs_in_n);
        end
    end

    a_r2_grant_needs_count: assert property (@(posedge clk) disable iff (!sup_rst_n)
        !en_n |-> (seen_q == TGT));
    a_r2_grant_on_last: assert property (@(posedge clk) disable iff (!sup_rst_n)
        (seen_q == TGT - 1'b1) && svc_stb |=> !en_n);
    a_r4_stays_granted: assert property (@(posedge clk) disable iff (!sup_rst_n)
        !en_n |=> !en_n);
    a_r8_no_stb_no_grant: assert property (@(posedge clk) disable iff (!sup_rst_n)
        en_n && !svc_stb |=> en_n);
endmodule

bind svc_enable_gate seg_checker #(.SVC_TARGET(SVC_TARGET), .CS_LANES(CS_LANES)) u_chk (.*);

// File: tb/svc_enable_gate_bench.sv
module svc_enable_gate_bench;
    logic       clk = 1'b0;
    logic       sup_rst_n = 1'b0;
    logic       svc_stb = 1'b0;
    logic [2:0] cs_in_n = 3'b111;
    logic       en_n;
    logic [2:0] cs_out_n;
    int total = 0;
    int bad = 0;

    svc_enable_gate u_svc_enable_gate (
        .clk(clk), .sup_rst_n(sup_rst_n), .svc_stb(svc_stb),
        .cs_in_n(cs_in_n), .en_n(en_n), .cs_out_n(cs_out_n)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); sup_rst_n = 1'b0; svc_stb = 1'b0;
        @(negedge clk); @(negedge clk); sup_rst_n = 1'b1;
        #1;
    endtask

    task automatic pulse();
        @(negedge clk); svc_stb = 1'b1;
        @(negedge clk); svc_stb = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        @(negedge clk); sup_rst_n = 1'b0; cs_in_n = 3'b000; #1;
        chk("R1 en during reset", {3'b0, en_n}, 4'b0001);
        chk("R5 cs during reset", {1'b0, cs_out_n}, 4'b0111);
        sup_rst_n = 1'b1;
    endtask

    task automatic t_grant_three();
        do_reset();
        cs_in_n = 3'b000;
        pulse();
        chk("R2 after one", {3'b0, en_n}, 4'b0001);
        pulse();
        chk("R2 after two", {3'b0, en_n}, 4'b0001);
        chk("R5 cs held off", {1'b0, cs_out_n}, 4'b0111);
        pulse();
        chk("R2 after three", {3'b0, en_n}, 4'b0000);
    endtask

    task automatic t_partial_then_reset();
        do_reset();
        pulse(); pulse();
        do_reset();
        pulse();
        chk("R3 count cleared", {3'b0, en_n}, 4'b0001);
        pulse();
        chk("R3 two after reset", {3'b0, en_n}, 4'b0001);
        pulse();
        chk("R3 third after reset", {3'b0, en_n}, 4'b0000);
    endtask

    task automatic t_saturate();
        do_reset();
        for (int i = 0; i < 7; i++) pulse();
        chk("R4 saturate", {3'b0, en_n}, 4'b0000);
    endtask

    task automatic t_cs_lanes();
        do_reset();
        pulse(); pulse(); pulse();
        for (int i = 0; i < 3; i++) begin
            cs_in_n = ~(3'b001 << i); #1;
            chk("R6 single lane", {1'b0, cs_out_n}, {1'b0, ~(3'b001 << i)});
        end
        cs_in_n = 3'b111; #1;
        chk("R6 all idle", {1'b0, cs_out_n}, 4'b0111);
        cs_in_n = 3'b000; #1;
        chk("R6 all active", {1'b0, cs_out_n}, 4'b0000);
    endtask

    task automatic t_stb_in_reset();
        @(negedge clk); sup_rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); svc_stb = 1'b1;
            @(negedge clk); svc_stb = 1'b0;
        end
        sup_rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R7 strobes in reset", {3'b0, en_n}, 4'b0001);
        pulse(); pulse();
        chk("R7 two real", {3'b0, en_n}, 4'b0001);
        pulse();
        chk("R7 third real", {3'b0, en_n}, 4'b0000);
    endtask

    task automatic t_idle_gaps();
        do_reset();
        pulse(); pulse();
        repeat (40) @(negedge clk);
        #1;
        chk("R8 idle no grant", {3'b0, en_n}, 4'b0001);
        pulse();
        chk("R8 gap then third", {3'b0, en_n}, 4'b0000);
    endtask

    task automatic t_fault_immediate();
        do_reset();
        pulse(); pulse(); pulse();
        cs_in_n = 3'b000;
        @(posedge clk); #5;
        sup_rst_n = 1'b0; #1;
        chk("R1 fault immediate", {3'b0, en_n}, 4'b0001);
        chk("R5 fault cs off", {1'b0, cs_out_n}, 4'b0111);
        @(negedge clk); sup_rst_n = 1'b1; #1;
        chk("R3 no grant after fault", {3'b0, en_n}, 4'b0001);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_grant_three();
        t_partial_then_reset();
        t_saturate();
        t_cs_lanes();
        t_stb_in_reset();
        t_idle_gaps();
        t_fault_immediate();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule